// File: doc/BRIEF.md
# Legacy address routing decoder

This block sits on the processor request path and decides, for every memory or I/O request, which of two downstream ports receives it: the graphics/secondary port or the default hub port. It first applies the fixed legacy display windows (the VGA frame buffer range, the VGA and monochrome adapter I/O ports, and all their ISA aliases). If none of those applies, it uses the programmable windows: one I/O base/limit window and two independent memory windows, a regular one and a prefetchable one.

Three control bits sit in a small register with a write strobe and a readback: VGA enable, monochrome adapter present, and ISA alias filtering. The window bounds arrive as static inputs. A request is decoded in the cycle its valid strobe is high. One cycle later the block presents a one-hot target with a valid flag. If software programs the illegal control setting, the block still behaves in a defined way and raises a sticky flag.

Top module: `legacy_route_decoder`

## Requirements
- R1: After reset the control register reads 0 (bit 0 VGA enable, bit 1 monochrome present, bit 2 ISA filter), the configuration-error flag is 0 and `rsp_valid` is 0.
- R2: `rsp_valid` is high exactly one cycle after `req_valid` was high, and low otherwise. While `rsp_valid` is high, `rsp_target` is one-hot, with bit 0 = hub and bit 1 = graphics. While it is low, `rsp_target` is 0. `rsp_write` repeats the request's write flag.
- R3: With VGA enable set, memory requests from 0xA0000 to 0xBFFFF (inclusive) go to graphics, whatever the windows hold.
- R4: With VGA enable set, I/O requests whose address bits [9:0] are 0x3B0–0x3BB or 0x3C0–0x3DF go to graphics. Bits [15:10] are ignored, and neither the I/O window nor the ISA filter has any effect.
- R5: With VGA enable set, I/O requests whose bits [9:0] are 0x3BC–0x3BF go to the hub, even when they lie inside the I/O window.
- R6: With VGA enable and monochrome present both set, I/O requests at bits [9:0] 0x3B0–0x3BB or 0x3BF go to the hub, while 0x3C0–0x3DF and the memory range still go to graphics.
- R7: With VGA enable clear, the legacy addresses are decoded only by the programmable windows.
- R8: An I/O request goes to graphics when io_base ≤ addr[15:0] ≤ io_limit. When the ISA filter is set, requests in that window whose address bits [9:8] are nonzero go to the hub instead.
- R9: A memory request goes to graphics when it lies inclusively inside either memory window. A request outside every window goes to the hub.
- R10: Writing VGA enable = 0 with monochrome present = 1 decodes as if both were 0. It also sets `cfg_err`, which stays set until reset, even after a legal value is written.
- R11: A control write is visible on `cfg_rdata` and in the routing from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: [0] VGA enable, [1] monochrome present, [2] ISA filter |
| cfg_rdata | output | 3 | Control register readback |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| io_base | input | 16 | I/O window lower bound (inclusive) |
| io_limit | input | 16 | I/O window upper bound (inclusive) |
| mem_base | input | 32 | Regular memory window lower bound |
| mem_limit | input | 32 | Regular memory window upper bound |
| pmem_base | input | 32 | Prefetchable memory window lower bound |
| pmem_limit | input | 32 | Prefetchable memory window upper bound |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_target | output | 2 | One-hot target: [0] hub, [1] graphics |
| rsp_write | output | 1 | Registered write flag of the request |

## Verification
The control bits are the only long-lived state, and any fault in them shows up on `cfg_rdata` in the next cycle. It also shows up in the next decode that touches a legacy address, which the bench issues right after every write. A wrong priority between the legacy and programmable decodes shows up as a wrong `rsp_target` one cycle after the request: the bench picks addresses that lie in a legacy window and in a programmable window at once. A sticky flag that is lost, or a flag that is never set, shows up on `cfg_err` in the cycle after the offending write or after a later legal write.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int ADDR_W = 32;
  localparam int IO_W   = 16;
  localparam int LOW_W  = 10;
  localparam int TGT_W  = 2;

  typedef enum logic [TGT_W-1:0] {
    TGT_NONE = 2'b00,
    TGT_HUB  = 2'b01,
    TGT_GFX  = 2'b10
  } tgt_e;

  typedef struct packed {
    logic isa;
    logic mda;
    logic vga;
  } ctrl_t;

  localparam logic [LOW_W-1:0] MONO_LO = 10'h3B0;
  localparam logic [LOW_W-1:0] MONO_HI = 10'h3BB;
  localparam logic [LOW_W-1:0] GAP_LO  = 10'h3BC;
  localparam logic [LOW_W-1:0] GAP_HI  = 10'h3BF;
  localparam logic [LOW_W-1:0] COL_LO  = 10'h3C0;
  localparam logic [LOW_W-1:0] COL_HI  = 10'h3DF;
  localparam logic [ADDR_W-1:0] FB_LO  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] FB_HI  = 32'h000B_FFFF;

  function automatic logic in_low(input logic [LOW_W-1:0] a,
                                  input logic [LOW_W-1:0] lo,
                                  input logic [LOW_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/lrd_ctrl_regs.sv
module lrd_ctrl_regs
  import lrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_rdata,
  output logic       cfg_err,
  output logic       vga_on,
  output logic       mda_on,
  output logic       isa_on
);
  ctrl_t ctrl_q;
  logic  bad_write;

  assign bad_write = cfg_we && !cfg_wdata[0] && cfg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_we) ctrl_q <= ctrl_t'(cfg_wdata);
      if (bad_write) cfg_err <= 1'b1;
    end
  end

  assign cfg_rdata = ctrl_q;
  assign vga_on    = ctrl_q.vga;
  assign mda_on    = ctrl_q.vga && ctrl_q.mda;
  assign isa_on    = ctrl_q.isa;

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r10_err_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |=> cfg_err);
  a_r11_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: rtl/lrd_legacy_match.sv
module lrd_legacy_match
  import lrd_pkg::*;
(
  input  logic              vga_on,
  input  logic              mda_on,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              leg_claim,
  output logic              leg_gfx
);
  logic [LOW_W-1:0] low;
  logic fb_hit, mono_hit, gap_hit, col_hit, mono_port;

  assign low       = addr[LOW_W-1:0];
  assign fb_hit    = (addr >= FB_LO) && (addr <= FB_HI);
  assign mono_hit  = in_low(low, MONO_LO, MONO_HI);
  assign gap_hit   = in_low(low, GAP_LO, GAP_HI);
  assign col_hit   = in_low(low, COL_LO, COL_HI);
  assign mono_port = mono_hit || (low == GAP_HI);

  always_comb begin
    leg_claim = 1'b0;
    leg_gfx   = 1'b0;
    if (vga_on) begin
      if (is_io) begin
        leg_claim = gap_hit || mono_hit || col_hit;
        if (gap_hit)                   leg_gfx = 1'b0;
        else if (mda_on && mono_port)  leg_gfx = 1'b0;
        else                           leg_gfx = mono_hit || col_hit;
      end else begin
        leg_claim = fb_hit;
        leg_gfx   = fb_hit;
      end
    end
  end

  always_comb begin
    if (leg_gfx) a_r4_gfx_needs_claim: assert (leg_claim && vga_on);
  end
endmodule

// File: rtl/lrd_window_match.sv
module lrd_window_match
  import lrd_pkg::*;
(
  input  logic              isa_on,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   io_base,
  input  logic [IO_W-1:0]   io_limit,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] mem_limit,
  input  logic [ADDR_W-1:0] pmem_base,
  input  logic [ADDR_W-1:0] pmem_limit,
  output logic              win_gfx,
  output logic              isa_block
);
  localparam int NWIN = 2;
  logic [IO_W-1:0] io_a;
  logic            io_hit;
  logic [NWIN-1:0] mem_hit;
  logic [ADDR_W-1:0] lo_b [NWIN];
  logic [ADDR_W-1:0] hi_b [NWIN];

  assign io_a      = addr[IO_W-1:0];
  assign io_hit    = (io_a >= io_base) && (io_a <= io_limit);
  assign isa_block = isa_on && (addr[9:8] != 2'b00);

  assign lo_b[0] = mem_base;
  assign hi_b[0] = mem_limit;
  assign lo_b[1] = pmem_base;
  assign hi_b[1] = pmem_limit;

  for (genvar g = 0; g < NWIN; g++) begin : g_mwin
    assign mem_hit[g] = (addr >= lo_b[g]) && (addr <= hi_b[g]);
  end

  assign win_gfx = is_io ? (io_hit && !isa_block) : (|mem_hit);

  always_comb begin
    if (is_io && isa_block) a_r8_isa_blocks: assert (!win_gfx);
  end
endmodule

// File: rtl/legacy_route_decoder.sv
module legacy_route_decoder
  import lrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  output logic [2:0]        cfg_rdata,
  output logic              cfg_err,
  input  logic [IO_W-1:0]   io_base,
  input  logic [IO_W-1:0]   io_limit,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] mem_limit,
  input  logic [ADDR_W-1:0] pmem_base,
  input  logic [ADDR_W-1:0] pmem_limit,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [TGT_W-1:0]  rsp_target,
  output logic              rsp_write
);
  logic vga_on, mda_on, isa_on;
  logic leg_claim, leg_gfx, win_gfx, isa_block;
  logic route_gfx;
  tgt_e tgt_d;

  lrd_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .vga_on(vga_on), .mda_on(mda_on), .isa_on(isa_on)
  );

  lrd_legacy_match u_leg (
    .vga_on(vga_on), .mda_on(mda_on), .is_io(req_is_io), .addr(req_addr),
    .leg_claim(leg_claim), .leg_gfx(leg_gfx)
  );

  lrd_window_match u_win (
    .isa_on(isa_on), .is_io(req_is_io), .addr(req_addr),
    .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .pmem_base(pmem_base), .pmem_limit(pmem_limit),
    .win_gfx(win_gfx), .isa_block(isa_block)
  );

  assign route_gfx = leg_claim ? leg_gfx : win_gfx;
  assign tgt_d     = route_gfx ? TGT_GFX : TGT_HUB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_target <= TGT_NONE;
      rsp_write  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_target <= req_valid ? tgt_d : TGT_NONE;
      rsp_write  <= req_valid && req_write;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_target) == 1));
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_target == '0));
  a_r3_fb_gfx: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && vga_on && req_addr >= FB_LO && req_addr <= FB_HI)
      |=> (rsp_target == TGT_GFX));
  a_r5_gap_hub: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && vga_on && req_addr[9:2] == 8'hEF)
      |=> (rsp_target == TGT_HUB));
  a_r8_isa_hub: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && isa_on && !leg_claim && req_addr[9:8] != 2'b00)
      |=> (rsp_target == TGT_HUB));
endmodule

// File: tb/sim_legacy_route_decoder.sv
`timescale 1ns/1ps
module sim_legacy_route_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic cfg_err;
  logic [15:0] io_base = '0, io_limit = '0;
  logic [31:0] mem_base = '0, mem_limit = '0, pmem_base = '0, pmem_limit = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_write;
  logic [1:0] rsp_target;

  int n_chk = 0;
  int n_err = 0;
  logic m_vga = 0, m_mda = 0, m_isa = 0;

  localparam logic [1:0] HUB = 2'b01;
  localparam logic [1:0] GFX = 2'b10;

  always #2.5 clk = ~clk;

  legacy_route_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .pmem_base(pmem_base), .pmem_limit(pmem_limit),
    .req_valid(req_valid), .req_write(req_write), .req_is_io(req_is_io),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_write(rsp_write)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic io, input logic [31:0] a);
    logic vga, mda;
    int p;
    vga = m_vga;
    mda = m_vga & m_mda;
    p = int'(a[9:0]);
    if (vga && io) begin
      if (p >= 'h3BC && p <= 'h3BF) return HUB;
      if (mda && p >= 'h3B0 && p <= 'h3BB) return HUB;
      if ((p >= 'h3B0 && p <= 'h3BB) || (p >= 'h3C0 && p <= 'h3DF)) return GFX;
    end
    if (vga && !io && a >= 32'hA0000 && a < 32'hC0000) return GFX;
    if (io) begin
      if (a[15:0] < io_base || a[15:0] > io_limit) return HUB;
      if (m_isa && p >= 256) return HUB;
      return GFX;
    end
    if (a >= mem_base && a <= mem_limit) return GFX;
    if (a >= pmem_base && a <= pmem_limit) return GFX;
    return HUB;
  endfunction

  task automatic cfg_write(input logic [2:0] v, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vga = v[0]; m_mda = v[1]; m_isa = v[2];
    check(req, 32'(cfg_rdata), 32'(v));
  endtask

  task automatic send(input logic io, input logic [31:0] a, input string req);
    logic [1:0] exp;
    exp = model(io, a);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a; req_write = a[0];
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " target"}, 32'(rsp_target), 32'(exp));
    check("R2 valid", 32'(rsp_valid), 1);
    check("R2 write", 32'(rsp_write), 32'(a[0]));
  endtask

  task automatic t_reset;
    check("R1 ctrl", 32'(cfg_rdata), 0);
    check("R1 err", 32'(cfg_err), 0);
    check("R1 valid", 32'(rsp_valid), 0);
    check("R1 target", 32'(rsp_target), 0);
  endtask

  task automatic t_io_window;
    io_base = 16'h1000; io_limit = 16'h1FFF;
    send(1, 32'h1000, "R8 low edge");
    send(1, 32'h1FFF, "R8 high edge");
    send(1, 32'h0FFF, "R8 below");
    send(1, 32'h2000, "R8 above");
    send(1, 32'h03C0, "R7 vga port no window");
    @(negedge clk);
    check("R2 idle", 32'(rsp_valid), 0);
    check("R2 idle target", 32'(rsp_target), 0);
    cfg_write(3'b100, "R11 isa write");
    send(1, 32'h1000, "R8 isa low quarter");
    send(1, 32'h1100, "R8 isa filtered");
    send(1, 32'h13FF, "R8 isa filtered top");
    send(1, 32'h1400, "R8 isa next block");
  endtask

  task automatic t_mem_window;
    mem_base = 32'h8000_0000; mem_limit = 32'h8FFF_FFFF;
    pmem_base = 32'hC000_0000; pmem_limit = 32'hC00F_FFFF;
    send(0, 32'h8000_0000, "R9 mem low");
    send(0, 32'h8FFF_FFFF, "R9 mem high");
    send(0, 32'h9000_0000, "R9 gap");
    send(0, 32'hC00F_FFFF, "R9 pmem high");
    send(0, 32'hC010_0000, "R9 pmem above");
    send(0, 32'h000A_0000, "R7 fb no vga");
  endtask

  task automatic t_vga;
    io_base = 16'h0000; io_limit = 16'hFFFF;
    cfg_write(3'b101, "R11 vga write");
    send(0, 32'h000A_0000, "R3 fb low");
    send(0, 32'h000B_FFFF, "R3 fb high");
    send(0, 32'h0009_FFFF, "R3 below fb");
    send(0, 32'h000C_0000, "R3 above fb");
    send(1, 32'h03C0, "R4 color port");
    send(1, 32'hF7DF, "R4 alias");
    send(1, 32'h03B0, "R4 mono port");
    send(1, 32'h03BB, "R4 mono top");
    send(1, 32'h03BC, "R5 gap low");
    send(1, 32'h07BF, "R5 gap alias");
    send(1, 32'h03E0, "R8 isa after legacy");
    io_base = 16'h2000; io_limit = 16'h2FFF;
    send(1, 32'h03C4, "R4 ignores window");
  endtask

  task automatic t_mda;
    cfg_write(3'b011, "R11 mda write");
    send(1, 32'h03B0, "R6 mono hub");
    send(1, 32'h07BB, "R6 mono alias hub");
    send(1, 32'h03BF, "R6 3BF hub");
    send(1, 32'h03C0, "R6 color gfx");
    send(1, 32'h03DF, "R6 color top gfx");
    send(0, 32'h000B_0000, "R6 fb gfx");
  endtask

  task automatic t_vga_off;
    io_base = 16'h0000; io_limit = 16'hFFFF;
    cfg_write(3'b000, "R11 clear");
    send(1, 32'h03BC, "R7 gap window");
    send(1, 32'h03C0, "R7 port window");
    mem_base = 32'h000A_0000; mem_limit = 32'h000A_FFFF;
    send(0, 32'h000A_8000, "R7 fb window");
    send(0, 32'h000B_0000, "R7 fb outside");
  endtask

  task automatic t_illegal;
    io_base = 16'h2000; io_limit = 16'h2FFF;
    cfg_write(3'b010, "R10 readback");
    check("R10 err set", 32'(cfg_err), 1);
    send(1, 32'h03B0, "R10 as off");
    send(1, 32'h03C0, "R10 as off color");
    io_base = 16'h0000; io_limit = 16'hFFFF;
    send(1, 32'h03BF, "R10 window applies");
    cfg_write(3'b001, "R10 legal write");
    check("R10 err sticky", 32'(cfg_err), 1);
    send(1, 32'h03B0, "R10 recovered");
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io_window();
    t_mem_window();
    t_vga();
    t_mda();
    t_vga_off();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule